// File: doc/BRIEF.md
# Burst Beat Tracker for a Ready-Valid Channel

This block watches one unidirectional ready-valid channel: either a request path from master to slave, or a response path from slave to master. A message can span several bus beats. The wire carries no length and no end-of-message marker. The block works out the beat count from the log2 size field of the first beat, the data-bus width, and whether the opcode carries data. It then frames every transferred beat with first and last flags and a running beat index.

Valid and ready pass straight through, so the block can act as an inline monitor or as the framing front end of a serializer. Three kinds of protocol error raise a single-cycle error pulse, with a cause vector that names which rule was broken:

- a control field changes between beats of one message;
- a request's address is not aligned to its transfer size;
- a stalled beat is altered or withdrawn before it transfers.

Top module: `burst_beat_tracker`

## Requirements
- R1: `dn_valid` equals `up_valid` and `up_ready` equals `dn_ready` in the same cycle. A beat transfers only in a cycle where both `up_valid` and `dn_ready` are high.
- R2: A data-carrying message of size field N spans 2^N / BUS_BYTES beats when 2^N exceeds BUS_BYTES, and one beat otherwise. N is clamped to MAX_SIZE_LG. With the defaults (8-byte bus), size 5 gives 4 beats, size 6 gives 8 beats, and sizes 2 and 3 give 1 beat.
- R3: With IS_REQ=1, opcodes 0 and 1 carry data. With IS_REQ=0, only opcode 1 carries data. A message whose opcode carries no data is always one beat, whatever its size field.
- R4: While `up_valid` is high, `first_beat` is high only on the first beat of a message, and `last_beat` is high only on its final beat. `beat_idx` reads 0 on the first beat and rises by one on each following beat.
- R5: Cycles with `up_valid` high and `dn_ready` low never advance `beat_idx`, however many such cycles occur.
- R6: On a transferred beat that is not the first of its message, a change in opcode, size, source or address against the first beat raises `err_pulse` with `err_cause` bit 0 in that same cycle. The message still ends at the length fixed by its first beat. A change in data alone raises no error.
- R7: With IS_REQ=1, a transferred first beat whose address has any of its low N bits set raises `err_pulse` with `err_cause` bit 1 in that cycle.
- R8: If the previous cycle held `up_valid` high with `dn_ready` low, a change to any payload field, or `up_valid` going low, raises `err_pulse` with `err_cause` bit 2 in the current cycle.
- R9: After reset, `beat_idx` is 0 and no flag or error is raised while `up_valid` is low. The next beat presented is the first of a message.
- R10: The beat after the final beat of a message is the first beat of a new message, with no idle cycle needed between them.
- R11: With IS_REQ=0, no alignment error is ever raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Beat offered by the sender |
| up_ready | output | 1 | Ready returned to the sender (copy of dn_ready) |
| up_opcode | input | 3 | Message opcode |
| up_size | input | SIZE_W | Log2 of the transfer size in bytes |
| up_source | input | SRC_W | Requester tag |
| up_addr | input | ADDR_W | Byte address |
| up_data | input | DATA_W | Beat data |
| dn_valid | output | 1 | Valid forwarded to the receiver |
| dn_ready | input | 1 | Ready from the receiver |
| first_beat | output | 1 | Presented beat opens a message |
| last_beat | output | 1 | Presented beat closes a message |
| beat_idx | output | CNT_W | Index of the presented beat within its message |
| err_pulse | output | 1 | A protocol error was seen this cycle |
| err_cause | output | 3 | Bit 0 control change, bit 1 misalignment, bit 2 stall disturbance |

## Verification
The assertions check the counter's progress on every cycle:

- it steps by one on each mid-message transfer;
- it returns to zero after a final beat;
- it stays still when no transfer happens;
- it never passes the latched length.

They also check, on every cycle, that data-less first beats are also last beats, that alignment errors fall only on first beats, that control-change errors fall only on later beats, and that a disturbed stall is always flagged.

Only the bench's scenarios can show the following:

- that the beat counts match the size and bus-width arithmetic;
- that the opcode decode differs between the two channel kinds;
- that data-only changes between beats stay silent;
- that a response channel ignores misaligned addresses.

// File: rtl/bbt_pkg.sv
package bbt_pkg;

  // Bit positions inside the error cause vector.
  localparam int CAUSE_CTRL  = 0;
  localparam int CAUSE_ALIGN = 1;
  localparam int CAUSE_HOLD  = 2;
  localparam int CAUSE_W     = 3;

  // Beats minus one for a message of 2^size_lg bytes on a bus of 2^bus_lg bytes.
  function automatic int unsigned beats_minus_one(input int unsigned size_lg,
                                                  input logic        carries,
                                                  input int unsigned bus_lg,
                                                  input int unsigned max_lg);
    int unsigned eff;
    eff = (size_lg > max_lg) ? max_lg : size_lg;
    if (!carries || eff <= bus_lg) return 0;
    return (32'd1 << (eff - bus_lg)) - 32'd1;
  endfunction

  // True when any address bit below the transfer size is set.
  function automatic logic is_misaligned(input logic [63:0] addr,
                                         input int unsigned size_lg);
    logic [63:0] mask;
    mask = (64'd1 << size_lg) - 64'd1;
    return |(addr & mask);
  endfunction

  // Opcode decode: which messages carry a data payload.
  function automatic logic opcode_has_data(input logic [2:0] opc,
                                           input logic       is_req);
    if (is_req) return (opc == 3'd0) || (opc == 3'd1);
    return opc == 3'd1;
  endfunction

endpackage

// File: rtl/bbt_beat_counter.sv
module bbt_beat_counter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             fire,
  input  logic [CNT_W-1:0] len_m1_now,
  output logic             at_start,
  output logic             at_end,
  output logic             first,
  output logic             last,
  output logic [CNT_W-1:0] beat_idx
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] len_cur;

  assign at_start = (cnt_q == '0);
  // The length is taken from the live fields on the first beat only.
  assign len_cur  = at_start ? len_m1_now : len_q;
  assign at_end   = (cnt_q == len_cur);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= '0;
    end else if (fire) begin
      if (at_start) len_q <= len_m1_now;
      cnt_q <= at_end ? '0 : cnt_q + 1'b1;
    end
  end

  assign first    = valid && at_start;
  assign last     = valid && at_end;
  assign beat_idx = cnt_q;

  // R10: a final transfer returns the counter to the opening beat.
  p_wrap_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire && at_end |=> cnt_q == '0);

  // R4: a mid-message transfer moves to the next index.
  p_step_on_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !at_end |=> cnt_q == $past(cnt_q) + 1'b1);

  // R5: no transfer, no movement.
  p_stall_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(cnt_q));

  // R2: the index never passes the latched length inside a message.
  p_idx_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !at_start |-> cnt_q <= len_q);

endmodule

// File: rtl/bbt_field_guard.sv
module bbt_field_guard #(
  parameter int HDR_W = 8,
  parameter int PAY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             ready,
  input  logic             at_start,
  input  logic             align_bad,
  input  logic [HDR_W-1:0] hdr,
  input  logic [PAY_W-1:0] pay,
  output logic             viol_ctrl,
  output logic             viol_align,
  output logic             viol_hold
);

  logic             fire;
  logic [HDR_W-1:0] hdr_q;
  logic [PAY_W-1:0] pay_q;
  logic             stall_q;

  assign fire = valid && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_q   <= '0;
      pay_q   <= '0;
      stall_q <= 1'b0;
    end else begin
      if (fire && at_start) hdr_q <= hdr;
      pay_q   <= pay;
      stall_q <= valid && !ready;
    end
  end

  assign viol_ctrl  = fire && !at_start && (hdr != hdr_q);
  assign viol_align = fire && at_start && align_bad;
  assign viol_hold  = stall_q && (!valid || (pay != pay_q));

  // R8: a stalled beat must come back unchanged, or be flagged.
  p_stall_payload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> (valid && $stable(pay)) || viol_hold);

endmodule

// File: rtl/burst_beat_tracker.sv
module burst_beat_tracker
  import bbt_pkg::*;
#(
  parameter int  BUS_BYTES   = 8,
  parameter int  MAX_SIZE_LG = 6,
  parameter int  SIZE_W      = 4,
  parameter int  SRC_W       = 4,
  parameter int  ADDR_W      = 32,
  parameter bit  IS_REQ      = 1'b1,
  localparam int BUS_LG      = $clog2(BUS_BYTES),
  localparam int DATA_W      = BUS_BYTES * 8,
  localparam int CNT_W       = (MAX_SIZE_LG > BUS_LG) ? (MAX_SIZE_LG - BUS_LG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [2:0]        up_opcode,
  input  logic [SIZE_W-1:0] up_size,
  input  logic [SRC_W-1:0]  up_source,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [DATA_W-1:0] up_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic              first_beat,
  output logic              last_beat,
  output logic [CNT_W-1:0]  beat_idx,
  output logic              err_pulse,
  output logic [2:0]        err_cause
);

  localparam int HDR_W = 3 + SIZE_W + SRC_W + ADDR_W;
  localparam int PAY_W = HDR_W + DATA_W;

  logic             fire;
  logic             carries;
  logic             align_bad;
  logic [CNT_W-1:0] len_m1_now;
  logic             at_start;
  logic             at_end;
  logic [HDR_W-1:0] hdr;
  logic [PAY_W-1:0] pay;
  logic             viol_ctrl;
  logic             viol_align;
  logic             viol_hold;

  // Handshake passes through untouched.
  assign dn_valid = up_valid;
  assign up_ready = dn_ready;
  assign fire     = up_valid && dn_ready;

  assign carries    = opcode_has_data(up_opcode, IS_REQ);
  assign len_m1_now = CNT_W'(beats_minus_one(int'(up_size), carries, BUS_LG, MAX_SIZE_LG));

  generate
    if (IS_REQ) begin : g_req_align
      assign align_bad = is_misaligned(64'(up_addr), int'(up_size));
    end else begin : g_rsp_align
      assign align_bad = 1'b0;
    end
  endgenerate

  assign hdr = {up_opcode, up_size, up_source, up_addr};
  assign pay = {hdr, up_data};

  bbt_beat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid     (up_valid),
    .fire      (fire),
    .len_m1_now(len_m1_now),
    .at_start  (at_start),
    .at_end    (at_end),
    .first     (first_beat),
    .last      (last_beat),
    .beat_idx  (beat_idx)
  );

  bbt_field_guard #(.HDR_W(HDR_W), .PAY_W(PAY_W)) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid     (up_valid),
    .ready     (dn_ready),
    .at_start  (at_start),
    .align_bad (align_bad),
    .hdr       (hdr),
    .pay       (pay),
    .viol_ctrl (viol_ctrl),
    .viol_align(viol_align),
    .viol_hold (viol_hold)
  );

  always_comb begin
    err_cause             = '0;
    err_cause[CAUSE_CTRL]  = viol_ctrl;
    err_cause[CAUSE_ALIGN] = viol_align;
    err_cause[CAUSE_HOLD]  = viol_hold;
  end
  assign err_pulse = |err_cause;

  // R3: an opening beat without data closes its message at once.
  p_nodata_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    first_beat && !carries |-> last_beat);

  // R7: alignment errors only land on opening beats.
  p_align_on_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_cause[CAUSE_ALIGN] |-> first_beat && dn_ready);

  // R6: control-change errors only land on later beats.
  p_ctrl_mid_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_cause[CAUSE_CTRL] |-> up_valid && !first_beat);

endmodule

// File: tb/sim_burst_beat_tracker.sv
module sim_burst_beat_tracker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        up_valid = 1'b0;
  logic        dn_ready = 1'b0;
  logic [2:0]  up_opcode = '0;
  logic [3:0]  up_size = '0;
  logic [3:0]  up_source = '0;
  logic [31:0] up_addr = '0;
  logic [63:0] up_data = '0;

  logic        up_ready, dn_valid, first_beat, last_beat, err_pulse;
  logic [2:0]  beat_idx, err_cause;
  logic        r_up_ready, r_dn_valid, r_first, r_last, r_err;
  logic [2:0]  r_idx, r_cause;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  burst_beat_tracker u0 (
    .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
    .up_opcode(up_opcode), .up_size(up_size), .up_source(up_source),
    .up_addr(up_addr), .up_data(up_data), .dn_valid(dn_valid), .dn_ready(dn_ready),
    .first_beat(first_beat), .last_beat(last_beat), .beat_idx(beat_idx),
    .err_pulse(err_pulse), .err_cause(err_cause)
  );

  burst_beat_tracker #(.IS_REQ(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(r_up_ready),
    .up_opcode(up_opcode), .up_size(up_size), .up_source(up_source),
    .up_addr(up_addr), .up_data(up_data), .dn_valid(r_dn_valid), .dn_ready(dn_ready),
    .first_beat(r_first), .last_beat(r_last), .beat_idx(r_idx),
    .err_pulse(r_err), .err_cause(r_cause)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drive a cycle at the falling edge, then let the combinational outputs settle.
  task automatic put(input logic v, input logic r, input logic [2:0] op,
                     input logic [3:0] sz, input logic [3:0] src,
                     input logic [31:0] a, input logic [63:0] d);
    @(negedge clk);
    up_valid = v; dn_ready = r; up_opcode = op; up_size = sz;
    up_source = src; up_addr = a; up_data = d;
    #1;
  endtask

  task automatic see(input string req, input logic f, input logic l,
                     input logic [2:0] idx, input logic [2:0] cause);
    chk(req, "first_beat", 32'(first_beat), 32'(f));
    chk(req, "last_beat",  32'(last_beat),  32'(l));
    chk(req, "beat_idx",   32'(beat_idx),   32'(idx));
    chk(req, "err_cause",  32'(err_cause),  32'(cause));
    chk(req, "err_pulse",  32'(err_pulse),  32'(cause != 3'b0));
  endtask

  // Number of beats for a data message on the 8-byte bus.
  function automatic int exp_beats(input int n);
    int m;
    m = (n > 6) ? 6 : n;
    return (m <= 3) ? 1 : (1 << m) / 8;
  endfunction

  task automatic t_reset();
    put(1'b0, 1'b0, 3'd4, 4'd3, 4'd0, 32'h0, 64'h0);
    see("R9", 1'b0, 1'b0, 3'd0, 3'b000);
    put(1'b1, 1'b1, 3'd4, 4'd3, 4'd0, 32'h0, 64'h0);
    see("R9", 1'b1, 1'b1, 3'd0, 3'b000);
    put(1'b0, 1'b0, 3'd4, 4'd3, 4'd0, 32'h0, 64'h0);
  endtask

  task automatic t_passthrough();
    put(1'b1, 1'b0, 3'd4, 4'd3, 4'd2, 32'h0, 64'h0);
    chk("R1", "dn_valid", 32'(dn_valid), 32'd1);
    chk("R1", "up_ready", 32'(up_ready), 32'd0);
    chk("R1", "idx before transfer", 32'(beat_idx), 32'd0);
    put(1'b1, 1'b1, 3'd4, 4'd3, 4'd2, 32'h0, 64'h0);
    chk("R1", "up_ready", 32'(up_ready), 32'd1);
    see("R1", 1'b1, 1'b1, 3'd0, 3'b000);
    put(1'b0, 1'b1, 3'd4, 4'd3, 4'd2, 32'h0, 64'h0);
    chk("R1", "dn_valid low", 32'(dn_valid), 32'd0);
  endtask

  task automatic t_write_burst();
    // size 5 write: 4 beats, long stall on beat 1, then a get back to back.
    put(1'b1, 1'b1, 3'd0, 4'd5, 4'd3, 32'h40, 64'hA0);
    see("R2 R4", 1'b1, 1'b0, 3'd0, 3'b000);
    for (int s = 0; s < 3; s++) begin
      put(1'b1, 1'b0, 3'd0, 4'd5, 4'd3, 32'h40, 64'hA1);
      see("R5", 1'b0, 1'b0, 3'd1, 3'b000);
    end
    put(1'b1, 1'b1, 3'd0, 4'd5, 4'd3, 32'h40, 64'hA1);
    see("R4", 1'b0, 1'b0, 3'd1, 3'b000);
    put(1'b1, 1'b1, 3'd0, 4'd5, 4'd3, 32'h40, 64'hA2);
    see("R4", 1'b0, 1'b0, 3'd2, 3'b000);
    put(1'b1, 1'b1, 3'd0, 4'd5, 4'd3, 32'h40, 64'hA3);
    see("R2 R4", 1'b0, 1'b1, 3'd3, 3'b000);
    put(1'b1, 1'b1, 3'd4, 4'd5, 4'd3, 32'h40, 64'h0);
    see("R3 R10", 1'b1, 1'b1, 3'd0, 3'b000);
    put(1'b0, 1'b0, 3'd4, 4'd5, 4'd3, 32'h40, 64'h0);
  endtask

  task automatic t_sizes();
    for (int n = 2; n <= 6; n++) begin
      int nb;
      nb = exp_beats(n);
      for (int b = 0; b < nb; b++) begin
        put(1'b1, 1'b1, 3'd1, 4'(n), 4'd5, 32'h0, 64'(b));
        see("R2", b == 0, b == nb - 1, 3'(b), 3'b000);
      end
    end
    put(1'b0, 1'b0, 3'd0, 4'd0, 4'd0, 32'h0, 64'h0);
  endtask

  task automatic t_ctrl_change();
    put(1'b1, 1'b1, 3'd0, 4'd4, 4'd1, 32'h20, 64'h11);
    see("R6", 1'b1, 1'b0, 3'd0, 3'b000);
    put(1'b1, 1'b1, 3'd0, 4'd4, 4'd2, 32'h20, 64'h12);
    see("R6", 1'b0, 1'b1, 3'd1, 3'b001);
    put(1'b1, 1'b1, 3'd0, 4'd4, 4'd1, 32'h20, 64'h21);
    see("R6", 1'b1, 1'b0, 3'd0, 3'b000);
    put(1'b1, 1'b1, 3'd0, 4'd4, 4'd1, 32'h20, 64'h99);
    see("R6 data only", 1'b0, 1'b1, 3'd1, 3'b000);
    put(1'b0, 1'b0, 3'd0, 4'd4, 4'd1, 32'h20, 64'h0);
  endtask

  task automatic t_misalign();
    put(1'b1, 1'b1, 3'd0, 4'd4, 4'd0, 32'h8, 64'h1);
    see("R7", 1'b1, 1'b0, 3'd0, 3'b010);
    put(1'b1, 1'b1, 3'd0, 4'd4, 4'd0, 32'h8, 64'h2);
    see("R7", 1'b0, 1'b1, 3'd1, 3'b000);
    put(1'b1, 1'b1, 3'd4, 4'd2, 4'd0, 32'h4, 64'h0);
    see("R7 aligned", 1'b1, 1'b1, 3'd0, 3'b000);
    put(1'b1, 1'b1, 3'd4, 4'd2, 4'd0, 32'h6, 64'h0);
    see("R7 get", 1'b1, 1'b1, 3'd0, 3'b010);
    put(1'b0, 1'b0, 3'd4, 4'd2, 4'd0, 32'h0, 64'h0);
  endtask

  task automatic t_stall_change();
    put(1'b1, 1'b0, 3'd4, 4'd3, 4'd1, 32'h0, 64'h5);
    see("R8", 1'b1, 1'b1, 3'd0, 3'b000);
    put(1'b1, 1'b0, 3'd4, 4'd3, 4'd1, 32'h0, 64'h6);
    see("R8 data moved", 1'b1, 1'b1, 3'd0, 3'b100);
    put(1'b0, 1'b0, 3'd4, 4'd3, 4'd1, 32'h0, 64'h6);
    chk("R8", "withdraw err_cause", 32'(err_cause), 32'h4);
    chk("R8", "withdraw err_pulse", 32'(err_pulse), 32'd1);
    put(1'b0, 1'b1, 3'd4, 4'd3, 4'd1, 32'h0, 64'h6);
    chk("R8", "quiet after", 32'(err_pulse), 32'd0);
  endtask

  task automatic t_response();
    // opcode 1 carries data on a response channel; addresses are not checked.
    put(1'b1, 1'b1, 3'd1, 4'd4, 4'd7, 32'h8, 64'h1);
    chk("R11", "rsp first", 32'(r_first), 32'd1);
    chk("R11", "rsp last", 32'(r_last), 32'd0);
    chk("R11", "rsp no align err", 32'(r_err), 32'd0);
    put(1'b1, 1'b1, 3'd1, 4'd4, 4'd7, 32'h8, 64'h2);
    chk("R3", "rsp idx", 32'(r_idx), 32'd1);
    chk("R3", "rsp last", 32'(r_last), 32'd1);
    put(1'b1, 1'b1, 3'd0, 4'd5, 4'd7, 32'h3, 64'h0);
    chk("R3", "rsp opcode0 single", 32'({r_first, r_last}), 32'h3);
    chk("R11", "rsp no err", 32'(r_err), 32'd0);
    put(1'b0, 1'b0, 3'd0, 4'd0, 4'd0, 32'h0, 64'h0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_passthrough();
    t_write_burst();
    t_sizes();
    t_ctrl_change();
    t_misalign();
    t_stall_change();
    t_response();
    repeat (2) @(posedge clk);
    summary();
  end

endmodule